// File: doc/BRIEF.md
# ADC Window Scan Sequencer

This block tests whether an analog voltage on one ADC input lies between two digital codes. It does not run a successive-approximation conversion. Instead it sends a fixed script of eleven scan vectors to an external boundary-scan engine. The vectors drive the ADC's enable, the DAC code, the input multiplexer enables, the sample/hold control and the active-low comparator precharge.

The script runs twice in two halves of the same shape. The first half samples the input with the DAC parked at midscale, then puts the lower limit on the DAC, precharges and compares. The second half does the same with the upper limit. The comparator bit that the scan engine captures while the vector after each compare is being shifted in decides the verdict. It must read 0 after the lower-limit compare and 1 after the upper-limit compare.

A run starts on a start pulse. The lower limit, the upper limit and the one-hot channel select are captured at that moment. The run ends with a one-cycle done pulse and a held pass or fail verdict. A limit pair with the lower code above the upper code is refused with an error flag, and no vector is issued.

Top module: `adc_window_seq`

## Requirements
- R1: Out of reset the block is idle with the following values.
  - vec_valid, done, pass, fail and range_err are 0.
  - The idle vector is: vec_adcen=0, vec_dac=0x200, vec_mux=0, vec_hold=1, vec_prech_n=1, vec_extest=0.
- R2: A start seen while idle with lo_lim > hi_lim is refused. In the next cycle done pulses with range_err=1 and pass=fail=0, and vec_valid stays 0. Equal limits are accepted.
- R3: An accepted run presents eleven steps in order. Columns give the step number, the DAC code, vec_hold and vec_prech_n. In the DAC column, "lo" and "hi" mean the captured lower and upper limits.

| Step | DAC code | vec_hold | vec_prech_n |
|---|---|---|---|
| 1 | 0x200 | 1 | 1 |
| 2 | 0x200 | 0 | 1 |
| 3 | 0x200 | 1 | 1 |
| 4 | lo | 1 | 1 |
| 5 | lo | 1 | 0 |
| 6 | 0x200 | 1 | 1 |
| 7 | 0x200 | 0 | 1 |
| 8 | 0x200 | 1 | 1 |
| 9 | hi | 1 | 1 |
| 10 | hi | 1 | 0 |
| 11 | 0x200 | 1 | 1 |

- R4: vec_extest is 0 (sample/preload instruction) for step 1 and 1 (external-test instruction) for steps 2 to 11.
- R5: During every step vec_adcen is 1 and vec_mux equals the channel select captured at start.
- R6: A step completes only in a cycle with vec_valid=1 and scan_ready=1. Otherwise the vector holds its value. The first step appears in the cycle after the accepting edge.
- R7: cmp_bit is sampled only at the completion of step 6 and step 11. pass=1 only if it was 0 at step 6 and 1 at step 11; otherwise fail=1. pass and fail are never both 1.
- R8: done is a one-cycle pulse in the cycle after step 11 completes, with vec_valid back at 0 and the idle vector restored. The verdict holds until the next accepted start, which clears it.
- R9: start is ignored while a run is in progress. Changes on lo_lim, hi_lim or chan_sel after the accepting edge do not affect the running script.
- R10: pin_dout and pin_dir are 0 on every channel. pin_pull is 0 for the channel driven on vec_mux and 1 for every other channel, so it is all ones when idle.
- R11: Whenever vec_valid=1 and vec_hold=0, vec_dac is 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a window test |
| chan_sel | input | NCH | One-hot ADC channel to test |
| lo_lim | input | DAC_W | Lower DAC code limit |
| hi_lim | input | DAC_W | Upper DAC code limit |
| scan_ready | input | 1 | Scan engine has shifted the current vector |
| cmp_bit | input | 1 | Comparator bit captured during that shift |
| vec_valid | output | 1 | A scan vector is presented |
| vec_extest | output | 1 | 0 = sample/preload instruction, 1 = external-test instruction |
| vec_adcen | output | 1 | ADC enable bit of the vector |
| vec_dac | output | DAC_W | DAC code bits of the vector |
| vec_mux | output | NCH | Input multiplexer enable bits |
| vec_hold | output | 1 | Sample (0) / hold (1) bit |
| vec_prech_n | output | 1 | Comparator precharge, active low |
| pin_dout | output | NCH | Port pin data bits for the analog pins |
| pin_dir | output | NCH | Port pin direction bits for the analog pins |
| pin_pull | output | NCH | Port pin pull-up enable bits |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Both window checks succeeded |
| fail | output | 1 | A window check failed |
| range_err | output | 1 | Start refused because lo_lim > hi_lim |

## Verification
Every registered result is due exactly one clock after the edge that caused it:

- The first vector follows the accepting start edge by one cycle.
- Each new vector follows the completing handshake edge by one cycle.
- done, with its verdict, follows the step-11 handshake edge by one cycle.
- A refused start shows done and range_err one cycle after the start edge.

The bench keeps a behavioural model that is updated on the same rising edge from the same inputs. The bench compares the model with every output on the following falling edge, so each comparison lands in the cycle where the value is due. Further checks confirm the verdict in the done cycle and that done has dropped in the cycle after it.

// File: rtl/adcw_pkg.sv
package adcw_pkg;
  localparam int unsigned STEP_CNT = 11;
  localparam int unsigned HALF_LEN = 5;
  localparam int unsigned LO_CHK   = 6;
  localparam int unsigned STEP_W   = $clog2(STEP_CNT + 1);

  // per-position controls of one half of the script
  typedef struct packed {
    logic hold;
    logic prech_n;
    logic use_lim;
  } row_ctl_t;

  function automatic row_ctl_t half_row(input logic [2:0] pos);
    row_ctl_t r;
    case (pos)
      3'd2:    r = '{hold: 1'b0, prech_n: 1'b1, use_lim: 1'b0};
      3'd4:    r = '{hold: 1'b1, prech_n: 1'b1, use_lim: 1'b1};
      3'd5:    r = '{hold: 1'b1, prech_n: 1'b0, use_lim: 1'b1};
      default: r = '{hold: 1'b1, prech_n: 1'b1, use_lim: 1'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/adcw_rowgen.sv
module adcw_rowgen
  import adcw_pkg::*;
#(
  parameter int unsigned DAC_W = 10
) (
  input  logic [STEP_W-1:0] step,
  input  logic [DAC_W-1:0]  lo,
  input  logic [DAC_W-1:0]  hi,
  output logic [DAC_W-1:0]  dac,
  output logic              hold,
  output logic              prech_n,
  output logic              extest
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  logic     second;
  logic [2:0] pos;
  row_ctl_t ctl;

  always_comb begin
    second  = step > STEP_W'(LO_CHK);
    pos     = second ? 3'(step - STEP_W'(HALF_LEN)) : 3'(step);
    ctl     = half_row(pos);
    dac     = ctl.use_lim ? (second ? hi : lo) : MID;
    hold    = ctl.hold;
    prech_n = ctl.prech_n;
    extest  = step != STEP_W'(1);
  end
endmodule

// File: rtl/adcw_ctrl.sv
module adcw_ctrl
  import adcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lim_bad,
  input  logic              scan_ready,
  input  logic              cmp_bit,
  output logic              busy,
  output logic              accept,
  output logic              ld,
  output logic              fin,
  output logic [STEP_W-1:0] step_nx,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              range_err
);
  logic [STEP_W-1:0] step_q;
  logic              lo_ok;
  logic              xfer, reject, last, at_lo;

  always_comb begin
    xfer    = busy && scan_ready;
    accept  = !busy && start && !lim_bad;
    reject  = !busy && start && lim_bad;
    last    = step_q == STEP_W'(STEP_CNT);
    at_lo   = step_q == STEP_W'(LO_CHK);
    ld      = accept || (xfer && !last);
    fin     = xfer && last;
    step_nx = accept ? STEP_W'(1) : step_q + STEP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      step_q    <= '0;
      lo_ok     <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      range_err <= 1'b0;
    end else begin
      done <= fin || reject;
      if (accept) begin
        busy      <= 1'b1;
        step_q    <= STEP_W'(1);
        lo_ok     <= 1'b0;
        pass      <= 1'b0;
        fail      <= 1'b0;
        range_err <= 1'b0;
      end else if (reject) begin
        range_err <= 1'b1;
        pass      <= 1'b0;
        fail      <= 1'b0;
      end
      if (xfer) begin
        if (at_lo) lo_ok <= !cmp_bit;
        if (last) begin
          busy   <= 1'b0;
          step_q <= '0;
          pass   <= lo_ok && cmp_bit;
          fail   <= !(lo_ok && cmp_bit);
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adcw_pinmask.sv
module adcw_pinmask #(
  parameter int unsigned NCH = 8
) (
  input  logic [NCH-1:0] mux,
  output logic [NCH-1:0] pin_dout,
  output logic [NCH-1:0] pin_dir,
  output logic [NCH-1:0] pin_pull
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    assign pin_dout[i] = 1'b0;
    assign pin_dir[i]  = 1'b0;
    assign pin_pull[i] = ~mux[i];
  end
endmodule

// File: rtl/adc_window_seq.sv
module adc_window_seq
  import adcw_pkg::*;
#(
  parameter int unsigned DAC_W = 10,
  parameter int unsigned NCH   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NCH-1:0]   chan_sel,
  input  logic [DAC_W-1:0] lo_lim,
  input  logic [DAC_W-1:0] hi_lim,
  input  logic             scan_ready,
  input  logic             cmp_bit,
  output logic             vec_valid,
  output logic             vec_extest,
  output logic             vec_adcen,
  output logic [DAC_W-1:0] vec_dac,
  output logic [NCH-1:0]   vec_mux,
  output logic             vec_hold,
  output logic             vec_prech_n,
  output logic [NCH-1:0]   pin_dout,
  output logic [NCH-1:0]   pin_dir,
  output logic [NCH-1:0]   pin_pull,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic             range_err
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  logic              accept, ld, fin;
  logic [STEP_W-1:0] step_nx;
  logic [DAC_W-1:0]  lo_q, hi_q;
  logic [NCH-1:0]    ch_q;
  logic [DAC_W-1:0]  row_dac;
  logic              row_hold, row_prech_n, row_extest;

  adcw_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .lim_bad   (lo_lim > hi_lim),
    .scan_ready(scan_ready),
    .cmp_bit   (cmp_bit),
    .busy      (vec_valid),
    .accept    (accept),
    .ld        (ld),
    .fin       (fin),
    .step_nx   (step_nx),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .range_err (range_err)
  );

  // step 1 never uses a limit, so the captured limits are ready in time
  adcw_rowgen #(.DAC_W(DAC_W)) u_row (
    .step   (step_nx),
    .lo     (lo_q),
    .hi     (hi_q),
    .dac    (row_dac),
    .hold   (row_hold),
    .prech_n(row_prech_n),
    .extest (row_extest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      ch_q <= '0;
    end else if (accept) begin
      lo_q <= lo_lim;
      hi_q <= hi_lim;
      ch_q <= chan_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_extest  <= 1'b0;
      vec_adcen   <= 1'b0;
      vec_dac     <= MID;
      vec_mux     <= '0;
      vec_hold    <= 1'b1;
      vec_prech_n <= 1'b1;
    end else if (ld) begin
      vec_extest  <= row_extest;
      vec_adcen   <= 1'b1;
      vec_dac     <= row_dac;
      vec_mux     <= accept ? chan_sel : ch_q;
      vec_hold    <= row_hold;
      vec_prech_n <= row_prech_n;
    end else if (fin) begin
      vec_extest  <= 1'b0;
      vec_adcen   <= 1'b0;
      vec_dac     <= MID;
      vec_mux     <= '0;
      vec_hold    <= 1'b1;
      vec_prech_n <= 1'b1;
    end
  end

  adcw_pinmask #(.NCH(NCH)) u_pin (
    .mux     (vec_mux),
    .pin_dout(pin_dout),
    .pin_dir (pin_dir),
    .pin_pull(pin_pull)
  );
endmodule

// File: rtl/adcw_chk.sv
module adcw_chk #(
  parameter int unsigned DAC_W = 10,
  parameter int unsigned NCH   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [DAC_W-1:0] lo_lim,
  input logic [DAC_W-1:0] hi_lim,
  input logic             scan_ready,
  input logic             vec_valid,
  input logic             vec_extest,
  input logic             vec_adcen,
  input logic [DAC_W-1:0] vec_dac,
  input logic             vec_hold,
  input logic             vec_prech_n,
  input logic             done,
  input logic             pass,
  input logic             fail
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  AST_BAD_LIMIT_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (start && !vec_valid && (lo_lim > hi_lim)) |=> !vec_valid); // R2
  AST_PRECH_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_prech_n) |-> vec_hold); // R3
  AST_FIRST_STEP_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid) |-> !vec_extest); // R4
  AST_ADC_ENABLED: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> vec_adcen); // R5
  AST_WAIT_FOR_READY: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !scan_ready) |=> (vec_valid && $stable(vec_dac) &&
      $stable(vec_hold) && $stable(vec_prech_n) && $stable(vec_extest))); // R6
  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_SAMPLE_AT_MID: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_hold) |-> (vec_dac == MID)); // R11
endmodule

bind adc_window_seq adcw_chk #(.DAC_W(DAC_W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .lo_lim     (lo_lim),
  .hi_lim     (hi_lim),
  .scan_ready (scan_ready),
  .vec_valid  (vec_valid),
  .vec_extest (vec_extest),
  .vec_adcen  (vec_adcen),
  .vec_dac    (vec_dac),
  .vec_hold   (vec_hold),
  .vec_prech_n(vec_prech_n),
  .done       (done),
  .pass       (pass),
  .fail       (fail)
);

// File: tb/adc_window_seq_tb_top.sv
`timescale 1ns/1ps
module adc_window_seq_tb_top;
  localparam int DW = 10;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NC-1:0] chan_sel = '0;
  logic [DW-1:0] lo_lim = '0, hi_lim = '0;
  logic scan_ready = 1'b0, cmp_bit = 1'b0;
  logic vec_valid, vec_extest, vec_adcen, vec_hold, vec_prech_n;
  logic [DW-1:0] vec_dac;
  logic [NC-1:0] vec_mux, pin_dout, pin_dir, pin_pull;
  logic done, pass, fail, range_err;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_window_seq #(.DAC_W(DW), .NCH(NC)) dut_i (.*);

  // ---------------- behavioural reference ----------------
  bit m_busy, m_done, m_pass, m_fail, m_err, m_lo_ok;
  int m_step;
  logic [DW-1:0] m_lo, m_hi;
  logic [NC-1:0] m_ch;

  function automatic void exp_row(input int s, input logic [DW-1:0] lo,
      input logic [DW-1:0] hi, output logic [DW-1:0] d, output bit h, output bit p);
    d = 10'h200; h = 1; p = 1;
    case (s)
      2, 7:  h = 0;
      4:     d = lo;
      5:     begin d = lo; p = 0; end
      9:     d = hi;
      10:    begin d = hi; p = 0; end
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0; m_err = 0;
      m_lo_ok = 0; m_step = 0; m_lo = '0; m_hi = '0; m_ch = '0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          if (lo_lim > hi_lim) begin
            m_done = 1; m_err = 1; m_pass = 0; m_fail = 0;
          end else begin
            m_busy = 1; m_step = 1; m_lo = lo_lim; m_hi = hi_lim; m_ch = chan_sel;
            m_pass = 0; m_fail = 0; m_err = 0; m_lo_ok = 0;
          end
        end
      end else if (scan_ready) begin
        if (m_step == 6) m_lo_ok = !cmp_bit;
        if (m_step == 11) begin
          m_busy = 0; m_done = 1;
          m_pass = m_lo_ok && cmp_bit; m_fail = !(m_lo_ok && cmp_bit);
        end else m_step++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [DW-1:0] ed; bit eh, ep;
      cyc++;
      if (m_busy) exp_row(m_step, m_lo, m_hi, ed, eh, ep);
      else begin ed = 10'h200; eh = 1; ep = 1; end
      check(vec_valid == m_busy, "R6 vec_valid", vec_valid, m_busy);
      check(vec_dac == ed, "R3 vec_dac", vec_dac, ed);
      check(vec_hold == eh, "R3 vec_hold", vec_hold, eh);
      check(vec_prech_n == ep, "R3 vec_prech_n", vec_prech_n, ep);
      check(vec_extest == (m_busy && m_step != 1), "R4 vec_extest", vec_extest, m_busy && m_step != 1);
      check(vec_adcen == m_busy, "R5 vec_adcen", vec_adcen, m_busy);
      check(vec_mux == (m_busy ? m_ch : '0), "R5 R9 vec_mux", vec_mux, m_busy ? m_ch : '0);
      check(done == m_done, "R8 done", done, m_done);
      check(pass == m_pass && fail == m_fail, "R7 verdict", {pass, fail}, {m_pass, m_fail});
      check(range_err == m_err, "R2 range_err", range_err, m_err);
      check(pin_dout == '0 && pin_dir == '0 && pin_pull == (m_busy ? ~m_ch : '1),
            "R10 pins", pin_pull, m_busy ? ~m_ch : '1);
      check(!(vec_valid && !vec_hold) || vec_dac == 10'h200, "R11 sample mid", vec_dac, 10'h200);
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        report();
      end
    end
  end

  task automatic report();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic kick(input logic [DW-1:0] lo, input logic [DW-1:0] hi, input logic [NC-1:0] ch);
    lo_lim = lo; hi_lim = hi; chan_sel = ch; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // scan engine: lat idle cycles before each handshake
  task automatic engine(input int lat, input bit c6, input bit c11, input bit disturb);
    for (int t = 1; t <= 11; t++) begin
      while (!vec_valid) @(negedge clk);
      repeat (lat) @(negedge clk);
      if (disturb && t == 3) begin
        start = 1; lo_lim = 10'h3FF; hi_lim = 10'h000; chan_sel = 8'h80;
      end
      if (disturb && t == 9) start = 0;
      scan_ready = 1;
      cmp_bit = (t == 6) ? c6 : (t == 11) ? c11 : t[0];
      @(negedge clk);
      scan_ready = 0; cmp_bit = 0;
    end
    check(done == 1, "R8 done after last step", done, 1);
    check(pass == (!c6 && c11), "R7 pass", pass, !c6 && c11);
    check(fail == !(!c6 && c11), "R7 fail", fail, !(!c6 && c11));
    @(negedge clk);
    check(done == 0, "R8 done single cycle", done, 0);
    check(pass == (!c6 && c11), "R8 verdict held", pass, !c6 && c11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(vec_valid == 0 && done == 0 && pass == 0 && fail == 0 && range_err == 0,
          "R1 reset outputs", {vec_valid, done, pass, fail, range_err}, 0);
    check(vec_dac == 10'h200 && vec_hold && vec_prech_n && !vec_adcen && !vec_extest && vec_mux == 0,
          "R1 idle vector", vec_dac, 10'h200);
    // passing window on channel 3
    kick(10'h123, 10'h143, 8'h08);
    check(vec_valid && !vec_extest && vec_dac == 10'h200, "R4 R6 first step", vec_extest, 0);
    engine(0, 0, 1, 0);
    // slow engine, below-window input
    kick(10'h123, 10'h143, 8'h01);
    engine(3, 1, 1, 0);
    // above-window input, start and limits disturbed mid-run
    kick(10'h050, 10'h2F0, 8'h20);
    engine(1, 0, 0, 1);
    repeat (2) @(negedge clk);
    // refused limits
    kick(10'h200, 10'h1FF, 8'h04);
    check(done && range_err && !vec_valid && !pass && !fail, "R2 refused start",
          {done, range_err, vec_valid}, 3'b110);
    @(negedge clk);
    check(!vec_valid && !done, "R2 no run after refusal", vec_valid, 0);
    // equal limits accepted
    kick(10'h1AA, 10'h1AA, 8'h40);
    check(vec_valid && range_err == 0, "R2 equal limits accepted", vec_valid, 1);
    engine(2, 0, 1, 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule